// File: doc/BRIEF.md
# POST Code Capture Buffer

This block keeps a record of the progress codes that boot firmware emits while it runs its power-on self-test. Firmware writes each code byte to a dedicated capture port. The block stores the byte at the slot its capture pointer names and then moves that pointer on by one. After 32 bytes the store is full. Any later capture write is thrown away, the capture pointer stays where it is, and the first such write raises a one-cycle overflow interrupt pulse for the interrupt status logic.

The host reads the stored codes through an indexed register window. A write to the address port sets a read pointer. The data port always shows the byte at that pointer. Each data-port read strobe moves the read pointer on by one while it lies inside the window 00h–1Fh. The read pointer and the capture pointer are separate, so the host can inspect the log while firmware is still adding to it.

Top module: `post_code_buffer`

## Requirements
- R1: After reset the capture pointer and the read pointer are both 00h, every slot reads 00h and `ovf_irq` is low.
- R2: A capture write while fewer than 32 bytes are stored puts `cap_data` into the slot at the capture pointer (the first write goes to 00h, the second to 01h, and so on) and advances the capture pointer by one.
- R3: Once 32 bytes are stored, further capture writes are discarded. The capture pointer holds and slot 1Fh keeps the 32nd byte.
- R4: The first discarded capture write after reset drives `ovf_irq` high for exactly the one cycle after that write. Later discarded writes raise no further pulse until the next reset.
- R5: `idx_rdata` shows the slot at the read pointer in the same cycle. It shows 00h whenever the read pointer is 20h or above.
- R6: An address-port write loads `idx_addr` into the read pointer. If it coincides with a data-port read strobe, the load wins and the pointer is not advanced.
- R7: A data-port read strobe with the read pointer in 00h–1Fh advances the pointer by one, so 1Fh steps to 20h.
- R8: A data-port read strobe with the read pointer at 20h or above leaves the pointer unchanged. In particular FFh does not wrap to 00h.
- R9: Capture writes never move the read pointer, and data-port reads and address-port writes never move the capture pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_wr | input | 1 | Capture port write strobe |
| cap_data | input | 8 | Code byte to capture |
| idx_addr_wr | input | 1 | Address port write strobe |
| idx_addr | input | 8 | Value loaded into the read pointer |
| idx_data_rd | input | 1 | Data port read strobe (advances read pointer) |
| idx_rdata | output | 8 | Byte at the read pointer |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench fills every slot with a position-dependent pattern and reads the whole window back. A capture pointer that wrapped instead of saturating would show up as an overwritten slot 00h or slot 1Fh. It drives the 33rd and 34th capture writes and looks for exactly one pulse, which catches a missing interrupt, a level-type interrupt or a repeated one. It parks the read pointer at 1Fh, 20h and FFh and strobes reads there. A pointer that wrapped into the window would return a stored nonzero code where 00h is due. It also issues a pointer load and a read strobe in the same cycle, and interleaves captures with reads, to expose wrong priority and pointers that interfere with each other.

// File: rtl/post_buf_pkg.sv
package post_buf_pkg;

  // True when a pointer value addresses a real slot.
  function automatic bit in_window(int unsigned ptr, int unsigned depth);
    return ptr < depth;
  endfunction

  // Next pointer value: advance by one inside the window, hold outside it.
  function automatic int unsigned step_sat(int unsigned ptr, int unsigned limit);
    return (ptr < limit) ? ptr + 1 : ptr;
  endfunction

endpackage

// File: rtl/post_cap_ctrl.sv
module post_cap_ctrl #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int WP_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_wr,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic             ovf_pulse
);
  import post_buf_pkg::*;

  localparam logic [WP_W-1:0] FULL = WP_W'(DEPTH);

  logic [WP_W-1:0] wp_q;
  logic            ovf_q;
  logic            ovf_seen_q;
  logic            cap_accept;
  logic            cap_discard;

  assign cap_accept  = cap_wr &&  in_window(32'(wp_q), DEPTH);
  assign cap_discard = cap_wr && !in_window(32'(wp_q), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q       <= '0;
      ovf_q      <= 1'b0;
      ovf_seen_q <= 1'b0;
    end else begin
      if (cap_wr) wp_q <= WP_W'(step_sat(32'(wp_q), DEPTH));
      ovf_q      <= cap_discard && !ovf_seen_q;
      ovf_seen_q <= ovf_seen_q || cap_discard;
    end
  end

  assign mem_we    = cap_accept;
  assign mem_waddr = wp_q[IDX_W-1:0];
  assign ovf_pulse = ovf_q;

  AST_WP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q <= FULL); // R2
  AST_WP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_accept |=> wp_q == $past(wp_q) + 1'b1); // R2
  AST_WP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_discard |=> $stable(wp_q)); // R3
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R4
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> wp_q == FULL); // R4
  AST_WP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_wr |=> $stable(wp_q)); // R9

endmodule

// File: rtl/post_rd_ptr.sv
module post_rd_ptr #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] rp,
  output logic              rp_in_win
);
  import post_buf_pkg::*;

  logic [ADDR_W-1:0] rp_q;
  logic              rd_advance;
  logic              rd_parked;

  assign rp_in_win  = in_window(32'(rp_q), DEPTH);
  assign rd_advance = step && !load &&  rp_in_win;
  assign rd_parked  = step && !load && !rp_in_win;

  always_ff @(posedge clk) begin
    if (!rst_n)          rp_q <= '0;
    else if (load)       rp_q <= load_val;
    else if (rd_advance) rp_q <= ADDR_W'(step_sat(32'(rp_q), DEPTH));
  end

  assign rp = rp_q;

  AST_RP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rp_q == $past(load_val)); // R6
  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_advance |=> rp_q == $past(rp_q) + 1'b1); // R7
  AST_RP_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_parked |=> $stable(rp_q)); // R8
  AST_RP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(rp_q)); // R9

endmodule

// File: rtl/post_store.sv
module post_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  import post_buf_pkg::*;

  logic [DATA_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (we) begin
      slot_q[waddr] <= wdata;
    end
  end

  always_comb begin
    if (in_window(32'(raddr), DEPTH)) rdata = slot_q[raddr[IDX_W-1:0]];
    else                              rdata = '0;
  end

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot_q[$past(waddr)] == $past(wdata)); // R2

endmodule

// File: rtl/post_code_buffer.sv
module post_code_buffer #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_wr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              idx_addr_wr,
  input  logic [ADDR_W-1:0] idx_addr,
  input  logic              idx_data_rd,
  output logic [DATA_W-1:0] idx_rdata,
  output logic              ovf_irq
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr;
  logic [ADDR_W-1:0] rp;
  logic             rp_in_win;

  post_cap_ctrl #(.DEPTH(DEPTH)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_wr    (cap_wr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .ovf_pulse (ovf_irq)
  );

  post_rd_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rdp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (idx_addr_wr),
    .load_val  (idx_addr),
    .step      (idx_data_rd),
    .rp        (rp),
    .rp_in_win (rp_in_win)
  );

  post_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (cap_data),
    .raddr (rp),
    .rdata (idx_rdata)
  );

  AST_READ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_in_win |-> idx_rdata == '0); // R5

endmodule

// File: tb/sim_post_code_buffer.sv
module sim_post_code_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_wr = 1'b0;
  logic [7:0] cap_data = '0;
  logic       idx_addr_wr = 1'b0;
  logic [7:0] idx_addr = '0;
  logic       idx_data_rd = 1'b0;
  logic [7:0] idx_rdata;
  logic       ovf_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  post_code_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .cap_data(cap_data),
    .idx_addr_wr(idx_addr_wr), .idx_addr(idx_addr), .idx_data_rd(idx_data_rd),
    .idx_rdata(idx_rdata), .ovf_irq(ovf_irq)
  );

  function automatic logic [7:0] code_of(int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One clock of stimulus: drive after the falling edge, release after the rising edge.
  task automatic cyc(bit cw, logic [7:0] cd, bit aw, logic [7:0] av, bit rs);
    @(negedge clk);
    cap_wr = cw; cap_data = cd; idx_addr_wr = aw; idx_addr = av; idx_data_rd = rs;
    @(posedge clk);
    #1;
    cap_wr = 1'b0; idx_addr_wr = 1'b0; idx_data_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 ovf_irq after reset", {7'b0, ovf_irq}, 8'h00);
    chk("R1 slot 00h after reset", idx_rdata, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R1 slot reads zero", idx_rdata, 8'h00);
      cyc(0, 0, 0, 0, 1);
    end
    chk("R5 pointer 20h reads zero", idx_rdata, 8'h00);

    // Park the read pointer at 05h, then fill the buffer (R2, R9)
    cyc(0, 0, 1, 8'h05, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, code_of(i), 0, 0, 0);
      chk("R4 no pulse while filling", {7'b0, ovf_irq}, 8'h00);
    end
    chk("R9 read pointer unmoved by captures", idx_rdata, code_of(5));

    // Read back the full window (R2, R5, R7)
    cyc(0, 0, 1, 8'h00, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 stored code in order", idx_rdata, code_of(i));
      cyc(0, 0, 0, 0, 1);
    end
    chk("R7 1Fh steps to 20h", idx_rdata, 8'h00);

    // Overflow (R3, R4)
    cyc(1, 8'hAA, 0, 0, 0);
    chk("R4 pulse after first discarded write", {7'b0, ovf_irq}, 8'h01);
    cyc(0, 0, 0, 0, 0);
    chk("R4 pulse lasts one cycle", {7'b0, ovf_irq}, 8'h00);
    cyc(0, 0, 1, 8'h1F, 0);
    chk("R3 slot 1Fh keeps last byte", idx_rdata, code_of(31));
    cyc(0, 0, 1, 8'h00, 0);
    chk("R3 slot 00h not overwritten", idx_rdata, code_of(0));
    cyc(1, 8'h55, 0, 0, 0);
    chk("R4 no second pulse", {7'b0, ovf_irq}, 8'h00);
    cyc(0, 0, 0, 0, 0);
    chk("R4 still quiet", {7'b0, ovf_irq}, 8'h00);
    chk("R3 slot 00h after second discard", idx_rdata, code_of(0));

    // Read pointer outside window (R8)
    cyc(0, 0, 1, 8'hFF, 0);
    chk("R5 pointer FFh reads zero", idx_rdata, 8'h00);
    cyc(0, 0, 0, 0, 1);
    chk("R8 FFh does not wrap", idx_rdata, 8'h00);
    cyc(0, 0, 1, 8'h1F, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R8 pointer held at 20h", idx_rdata, 8'h00);

    // Load wins over simultaneous read strobe (R6)
    cyc(0, 0, 1, 8'h03, 1);
    chk("R6 load beats read strobe", idx_rdata, code_of(3));
    cyc(0, 0, 0, 0, 1);
    chk("R7 advance after load", idx_rdata, code_of(4));

    // Reads do not disturb capture order (R9), and reset clears overflow (R1)
    do_reset();
    chk("R1 ovf cleared by reset", {7'b0, ovf_irq}, 8'h00);
    cyc(1, 8'h3C, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 8'h10, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 8'hC3, 0, 0, 1);
    cyc(0, 0, 1, 8'h00, 0);
    chk("R9 first capture at 00h", idx_rdata, 8'h3C);
    cyc(0, 0, 0, 0, 1);
    chk("R9 second capture at 01h", idx_rdata, 8'hC3);
    cyc(0, 0, 0, 0, 1);
    chk("R1 unwritten slot still zero", idx_rdata, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule